// File: doc/BRIEF.md
# Tagged Ordered-Insertion Sorter

This block keeps a short list of tag/payload entries in tag order at all times. A producer pushes one entry per cycle through a valid/ready input stream. The block presents each new entry to every storage node at once. Each node looks only at its own contents and those of its two neighbours, then decides whether to keep its entry, take its lower neighbour's entry, or capture the new one. The entry is therefore in its sorted place one clock after it is accepted. Ordering uses only the tag, for example a timestamp. The payload travels with its tag unchanged. Entries with equal tags leave in the order they arrived.

The head entry, meaning the one that sorts first, is offered on a valid/ready output stream. The consumer can look at the head tag and payload for as long as it likes before it takes the entry. Taking the head removes it, and every other entry moves one node toward the head. An insert and a removal in the same cycle are both carried out. When every node is occupied, `full` rises. One further entry can then be parked in a single-entry stall buffer. That entry is inserted as soon as a removal frees room. List depth, sort direction, tag width and payload width are elaboration parameters.

Back-pressure rules are as follows. The input transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while the stall buffer holds an entry. The output transfers, and removes the head, on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head stays where it is.

Top module: `tagged_linear_sorter`

## Requirements
- R1: An entry accepted while the list has room and the stall buffer is empty is in the list at the next clock edge, so occupancy rises by exactly one. An accepted entry that sorts ahead of all stored entries appears on `out_tag`/`out_data` with `out_valid` high in the following cycle.
- R2: With `DESCEND`=0, entries leave in non-decreasing tag order, compared as unsigned numbers. With `DESCEND`=1 they leave in non-increasing order. Stored entries are always in this order from the head outward.
- R3: Each payload stays paired with the tag it was accepted with.
- R4: `full` is high exactly when all `DEPTH` nodes hold entries. An entry accepted while the list is full and no removal takes place goes into the stall buffer, and `in_ready` goes low from the next cycle.
- R5: A removal (`out_valid` and `out_ready` both high) discards the head entry. The remaining entries keep their order, and occupancy falls by one when nothing is inserted in the same cycle.
- R6: `out_valid` is low when the list is empty. While `out_ready` is low and no entry is inserted, `out_tag` and `out_data` hold their values.
- R7: A removal and an insertion in the same cycle both take effect, so occupancy is unchanged. The new entry is placed among the entries that remain after the removal. A parked entry is inserted in the first cycle that has a removal.
- R8: Entries with equal tags leave in the order they were accepted.
- R9: After reset the list is empty, `full` is low and `in_ready` is high.
- R10: Stored entries occupy a contiguous run of nodes starting at the head node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers an entry |
| in_ready | output | 1 | Entry can be taken (stall buffer empty) |
| in_tag | input | TAG_W | Sort key of the offered entry |
| in_data | input | DATA_W | Payload of the offered entry |
| out_valid | output | 1 | A head entry is present |
| out_ready | input | 1 | Consumer takes the head entry |
| out_tag | output | TAG_W | Head tag |
| out_data | output | DATA_W | Head payload |
| full | output | 1 | Every node is occupied |

## Verification
The bench targets equal tags, because a comparator that is not strict would let a later duplicate overtake an earlier one and the payloads would come out in the wrong order. It also drives a removal and an insertion in the same cycle into a full list. A design that evaluated the insertion against the list before the removal would drop the entry, duplicate it, or put it one node off. The third target is the full boundary. The bench checks that the extra entry is parked rather than lost, that `in_ready` falls one cycle later, and that the parked entry comes back in order on the next removal. A long pseudo-random run with a small tag range compares every head, payload and flag, cycle by cycle, against an arithmetic model of the list.

// File: rtl/tls_pkg.sv
package tls_pkg;
  // What one storage node loads at the next clock edge.
  typedef enum logic [1:0] {
    ACT_KEEP      = 2'd0,  // keep own (post-removal) view
    ACT_TAKE_NEW  = 2'd1,  // capture the broadcast entry
    ACT_TAKE_PREV = 2'd2   // take the headward neighbour's view
  } node_act_e;
endpackage

// File: rtl/tls_precedes.sv
// Strict ordering test: high when tag a must sort ahead of tag b.
// Strictness keeps equal tags in arrival order.
module tls_precedes #(
  parameter int TAG_W   = 8,
  parameter bit DESCEND = 1'b0
) (
  input  logic [TAG_W-1:0] a,
  input  logic [TAG_W-1:0] b,
  output logic             ahead
);
  generate
    if (DESCEND) begin : g_desc
      assign ahead = (a > b);
    end else begin : g_asc
      assign ahead = (a < b);
    end
  endgenerate
endmodule

// File: rtl/tls_node.sv
// One sorter node. It sees the broadcast entry, its own post-removal view
// and its headward neighbour's view and flag, and nothing else.
module tls_node
  import tls_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 8,
  parameter bit DESCEND = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic [DATA_W-1:0] new_data,
  input  logic              cur_v,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [DATA_W-1:0] cur_data,
  input  logic              prev_v,
  input  logic [TAG_W-1:0]  prev_tag,
  input  logic [DATA_W-1:0] prev_data,
  input  logic              prev_behind,
  output logic              behind,
  output logic              q_v,
  output logic [TAG_W-1:0]  q_tag,
  output logic [DATA_W-1:0] q_data
);
  logic      new_ahead;
  node_act_e act;

  tls_precedes #(.TAG_W(TAG_W), .DESCEND(DESCEND)) u_cmp (
    .a     (new_tag),
    .b     (cur_tag),
    .ahead (new_ahead)
  );

  // An empty node always sorts after a real entry.
  assign behind = ins_en && (!cur_v || new_ahead);

  always_comb begin
    if (!behind)          act = ACT_KEEP;
    else if (prev_behind) act = ACT_TAKE_PREV;
    else                  act = ACT_TAKE_NEW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v    <= 1'b0;
      q_tag  <= '0;
      q_data <= '0;
    end else begin
      unique case (act)
        ACT_TAKE_NEW: begin
          q_v    <= 1'b1;
          q_tag  <= new_tag;
          q_data <= new_data;
        end
        ACT_TAKE_PREV: begin
          q_v    <= prev_v;
          q_tag  <= prev_tag;
          q_data <= prev_data;
        end
        default: begin
          q_v    <= cur_v;
          q_tag  <= cur_tag;
          q_data <= cur_data;
        end
      endcase
    end
  end
endmodule

// File: rtl/tls_stall_buf.sv
// Single-entry park for an entry that arrives while the list has no room.
module tls_stall_buf #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              room,
  output logic              in_ready,
  output logic              cand_v,
  output logic [TAG_W-1:0]  cand_tag,
  output logic [DATA_W-1:0] cand_data
);
  logic              park_v;
  logic [TAG_W-1:0]  park_tag;
  logic [DATA_W-1:0] park_data;

  assign in_ready  = !park_v;
  assign cand_v    = park_v || in_valid;
  assign cand_tag  = park_v ? park_tag  : in_tag;
  assign cand_data = park_v ? park_data : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_v    <= 1'b0;
      park_tag  <= '0;
      park_data <= '0;
    end else if (park_v) begin
      if (room) park_v <= 1'b0;
    end else if (in_valid && !room) begin
      park_v    <= 1'b1;
      park_tag  <= in_tag;
      park_data <= in_data;
    end
  end
endmodule

// File: rtl/tagged_linear_sorter.sv
module tagged_linear_sorter #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 8,
  parameter bit DESCEND = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  output logic              full
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]       q_v;
  logic [TAG_W-1:0]       q_tag  [DEPTH];
  logic [DATA_W-1:0]      q_data [DEPTH];
  logic [DEPTH*TAG_W-1:0] q_tag_flat;

  // Post-removal view of each node.
  logic [DEPTH-1:0]  v_v;
  logic [TAG_W-1:0]  v_tag  [DEPTH];
  logic [DATA_W-1:0] v_data [DEPTH];
  logic [DEPTH-1:0]  behind;

  logic              pop, room, ins_en, cand_v;
  logic [TAG_W-1:0]  cand_tag;
  logic [DATA_W-1:0] cand_data;

  assign out_valid = q_v[0];
  assign out_tag   = q_tag[0];
  assign out_data  = q_data[0];
  assign full      = q_v[LAST];
  assign pop       = out_valid && out_ready;
  assign room      = !full || pop;
  assign ins_en    = cand_v && room;

  tls_stall_buf #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_park (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_data   (in_data),
    .room      (room),
    .in_ready  (in_ready),
    .cand_v    (cand_v),
    .cand_tag  (cand_tag),
    .cand_data (cand_data)
  );

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_node
      assign q_tag_flat[i*TAG_W +: TAG_W] = q_tag[i];

      if (i == LAST) begin : g_tail
        assign v_v[i]    = pop ? 1'b0 : q_v[i];
        assign v_tag[i]  = q_tag[i];
        assign v_data[i] = q_data[i];
      end else begin : g_mid
        assign v_v[i]    = pop ? q_v[i+1]    : q_v[i];
        assign v_tag[i]  = pop ? q_tag[i+1]  : q_tag[i];
        assign v_data[i] = pop ? q_data[i+1] : q_data[i];
      end

      logic              pv, pb;
      logic [TAG_W-1:0]  pt;
      logic [DATA_W-1:0] pd;
      if (i == 0) begin : g_head
        assign pv = 1'b0;
        assign pt = '0;
        assign pd = '0;
        assign pb = 1'b0;
      end else begin : g_link
        assign pv = v_v[i-1];
        assign pt = v_tag[i-1];
        assign pd = v_data[i-1];
        assign pb = behind[i-1];
      end

      tls_node #(.TAG_W(TAG_W), .DATA_W(DATA_W), .DESCEND(DESCEND)) u_node (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_en      (ins_en),
        .new_tag     (cand_tag),
        .new_data    (cand_data),
        .cur_v       (v_v[i]),
        .cur_tag     (v_tag[i]),
        .cur_data    (v_data[i]),
        .prev_v      (pv),
        .prev_tag    (pt),
        .prev_data   (pd),
        .prev_behind (pb),
        .behind      (behind[i]),
        .q_v         (q_v[i]),
        .q_tag       (q_tag[i]),
        .q_data      (q_data[i])
      );
    end
  endgenerate
endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 8,
  parameter bit DESCEND = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [TAG_W-1:0]       out_tag,
  input logic [DATA_W-1:0]      out_data,
  input logic                   full,
  input logic [DEPTH-1:0]       node_v,
  input logic [DEPTH*TAG_W-1:0] node_tags
);
  logic order_bad, hole;
  int   occ;

  always_comb begin
    order_bad = 1'b0;
    hole      = 1'b0;
    for (int i = 0; i + 1 < DEPTH; i++) begin
      if (node_v[i] && node_v[i+1]) begin
        if (DESCEND) begin
          if (node_tags[i*TAG_W +: TAG_W] < node_tags[(i+1)*TAG_W +: TAG_W]) order_bad = 1'b1;
        end else begin
          if (node_tags[i*TAG_W +: TAG_W] > node_tags[(i+1)*TAG_W +: TAG_W]) order_bad = 1'b1;
        end
      end
      if (!node_v[i] && node_v[i+1]) hole = 1'b1;
    end
  end

  assign occ = $countones(node_v);

  AST_SORTED_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) !order_bad); // R2
  AST_CONTIG_FILL: assert property (@(posedge clk) disable iff (!rst_n) !hole); // R10
  AST_ONE_CLK_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && in_valid && in_ready && !(out_valid && out_ready)) |=> (occ == $past(occ) + 1)); // R1
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_ready && !in_valid) |=> (occ == $past(occ) - 1)); // R5
  AST_PARK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(out_valid && out_ready) && in_valid && in_ready) |=> (!in_ready && full)); // R4
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_ready && !in_valid) |=> ($stable(out_tag) && $stable(out_data))); // R6
  AST_SWAP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && out_ready && in_valid && in_ready) |=> full); // R7
endmodule

bind tagged_linear_sorter tls_checker #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .DESCEND(DESCEND)
) u_tls_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tag   (out_tag),
  .out_data  (out_data),
  .full      (full),
  .node_v    (q_v),
  .node_tags (q_tag_flat)
);

// File: tb/tagged_linear_sorter_test.sv
`timescale 1ns/1ps
module tagged_linear_sorter_test;
  localparam int DEPTH   = 4;
  localparam int TAG_W   = 3;
  localparam int DATA_W  = 4;
  localparam bit DESCEND = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, full;
  logic [TAG_W-1:0]  out_tag;
  logic [DATA_W-1:0] out_data;

  always #10 clk = ~clk;  // 50 MHz

  tagged_linear_sorter #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .DESCEND(DESCEND)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_data(out_data), .full(full)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // Arithmetic model of the list, the stall buffer and the rules.
  int mtag [DEPTH];
  int mdat [DEPTH];
  int mcnt = 0;
  bit mbv = 0;
  int mbt = 0, mbd = 0;

  function automatic bit ahead(int a, int b);
    return DESCEND ? (a > b) : (a < b);
  endfunction

  task automatic m_insert(int t, int d);
    int p = mcnt;
    for (int i = mcnt - 1; i >= 0; i--) if (ahead(t, mtag[i])) p = i;
    for (int i = mcnt; i > p; i--) begin
      mtag[i] = mtag[i-1];
      mdat[i] = mdat[i-1];
    end
    mtag[p] = t;
    mdat[p] = d;
    mcnt++;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mcnt = 0;
      mbv = 0;
    end else begin
      if (mcnt > 0 && out_ready) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          mtag[i] = mtag[i+1];
          mdat[i] = mdat[i+1];
        end
        mcnt--;
      end
      if (mbv) begin
        if (mcnt < DEPTH) begin
          m_insert(mbt, mbd);
          mbv = 0;
        end
      end else if (in_valid) begin
        if (mcnt < DEPTH) m_insert(int'(in_tag), int'(in_data));
        else begin
          mbv = 1;
          mbt = int'(in_tag);
          mbd = int'(in_data);
        end
      end
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Compare all outputs with the model at the falling edge, then drive.
  task automatic step(bit iv, int t, int d, bit rdy);
    @(negedge clk);
    check("R6 out_valid", int'(out_valid), int'(mcnt > 0));
    if (mcnt > 0) begin
      check("R2 head tag", int'(out_tag), mtag[0]);
      check("R3 head data", int'(out_data), mdat[0]);
    end
    check("R4 full", int'(full), int'(mcnt == DEPTH));
    check("R4 in_ready", int'(in_ready), int'(!mbv));
    in_valid  = iv;
    in_tag    = TAG_W'(t);
    in_data   = DATA_W'(d);
    out_ready = rdy;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 full", int'(full), 0);
    check("R9 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // R1: single entry visible one clock later
    step(1, 5, 1, 0);
    step(0, 0, 0, 0);
    check("R1 head valid", int'(out_valid), 1);
    check("R1 head tag", int'(out_tag), 5);

    // R8: duplicates, then fill to full
    step(1, 5, 2, 0);
    step(1, 3, 3, 0);
    step(1, 7, 4, 0);
    step(0, 0, 0, 0);
    check("R4 full at depth", int'(full), 1);

    // R4: arrival while full is parked
    step(1, 0, 5, 0);
    step(0, 0, 0, 0);
    check("R4 parked blocks input", int'(in_ready), 0);
    check("R6 head held", int'(out_tag), 3);

    // R7: removal lets the parked entry in, occupancy stays
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R7 parked entry at head", int'(out_tag), 0);
    check("R7 still full", int'(full), 1);

    // R7: removal plus new insertion in one cycle
    step(1, 6, 6, 1);
    step(0, 0, 0, 0);
    check("R7 swap keeps full", int'(full), 1);

    // R5/R8: drain, duplicates leave in arrival order
    step(0, 0, 0, 1);
    check("R8 first duplicate data", int'(out_data), 1);
    step(0, 0, 0, 1);
    check("R8 second duplicate data", int'(out_data), 2);
    repeat (4) step(0, 0, 0, 1);
    check("R5 drained", int'(out_valid), 0);

    // Sweep: every tag after every tag into a one-entry list
    for (int a = 0; a < (1 << TAG_W); a++) begin
      for (int b = 0; b < (1 << TAG_W); b++) begin
        step(1, a, 1, 0);
        step(1, b, 2, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
      end
    end

    // Pseudo-random traffic, small tag range for many ties
    for (int n = 0; n < 6000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] < 10, int'(lfsr[6:4]), n % 16, lfsr[11:8] < 6);
    end
    repeat (DEPTH + 3) step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R5 empty at end", int'(out_valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule